// File: doc/BRIEF.md
# Clock-Crossing Elastic Buffer with Skip/Insert Rate Matching

This block sits between a receive path clocked by a recovered clock and logic clocked by a local clock. Words are written on the recovered side and read on the local side through a small dual-clock FIFO. Small frequency offsets between the two clocks make its fill level drift. The buffer corrects the drift by deleting or duplicating only words that the upstream path has flagged as rate-matching filler (idle or skip characters), so payload words are never lost or repeated.

Each side computes a fill level from its own pointer and a synchronized Gray-coded copy of the other side's pointer. When the write side sees the level at or above a high threshold, an arriving flagged word is discarded. When the read side sees the level at or below a low threshold, a flagged word at the head is presented twice. Reading begins only once the buffer is half full. If the buffer still runs full or empty, a sticky error flag is raised and the affected side pauses until the level is back at the half-full point.

Top module: `elastic_buf`

## Requirements
- R1: While no error flag is set, every word that was not deleted leaves `rd_data` in the order it was written. No payload word (skip flag 0) is lost or duplicated.
- R2: After reset, `rd_valid` stays 0 until the read side has seen at least half the depth (8 words with defaults) in the buffer. Writing 7 words never produces output.
- R3: When the write-side fill level is at or above `HI_TH` (12) and an arriving word has `wr_skip` = 1, that word is discarded and `skip_evt` pulses for one write clock on the edge that handles it.
- R4: Only words with the skip flag set are ever deleted or repeated. `skip_evt` never follows a word with `wr_skip` = 0, and a duplicated word always has `rd_skip` = 1.
- R5: When the read-side fill level is at or below `LO_TH` (4) and the head word carries the skip flag, the word is output and `ins_evt` is 1 in that cycle. The next valid output is the same word again.
- R6: A flagged word is repeated at most once. Two `skip_evt` pulses are at least `MIN_GAP`+1 write clocks apart, and two `ins_evt` pulses are at least `MIN_GAP`+1 read clocks apart.
- R7: A word that arrives while the write side sees the buffer full sets the sticky `ovf_err`. Further arriving words are discarded until the write-side level falls to half depth.
- R8: A read request while the read side sees the buffer empty sets the sticky `udf_err` and gives no valid word. Reading then pauses until the level is back at half depth.
- R9: After reset all outputs are 0.
- R10: In a read clock with `rd_en` = 0, no word is consumed and `rd_valid` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst_n | input | 1 | Active-low reset, write domain |
| wr_en | input | 1 | A word is offered this cycle |
| wr_data | input | DW | Word to store |
| wr_skip | input | 1 | Word may be deleted or repeated |
| skip_evt | output | 1 | One-cycle pulse: a flagged word was deleted |
| ovf_err | output | 1 | Sticky overflow flag |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst_n | input | 1 | Active-low reset, read domain |
| rd_en | input | 1 | Local side consumes a word this cycle |
| rd_data | output | DW | Word delivered |
| rd_skip | output | 1 | Delivered word carries the skip flag |
| rd_valid | output | 1 | `rd_data` holds a delivered word |
| ins_evt | output | 1 | This flagged word will be presented again |
| udf_err | output | 1 | Sticky underflow flag |

## Verification
A wrong pointer or fill computation shows up as a word that is out of order, lost or doubled. The bench compares every delivered word against a queue built from the write stream, so this is caught within one read of the fault. A bad threshold or spacing decision shows up as a deletion or duplication of a payload word, or as two events too close together, at the pulse itself. A missed correction drives the level to a rail, which raises a sticky error flag within a few dozen cycles of sustained rate mismatch. The sweeps run the two sides at equal rates, with a slow reader and with a slow writer, and then force both rails.

// File: rtl/elbuf_pkg.sv
package elbuf_pkg;

    typedef enum logic {
        WR_PASS  = 1'b0,
        WR_DRAIN = 1'b1
    } wr_mode_e;

    typedef enum logic {
        RD_FILL = 1'b0,
        RD_RUN  = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/elbuf_sync.sv
module elbuf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = d;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/elbuf_mem.sv
module elbuf_mem #(
    parameter int W  = 9,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/elbuf_wr.sv
module elbuf_wr
    import elbuf_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int HI_TH   = 12,
    parameter int MIN_GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_en,
    input  logic [DW-1:0] in_data,
    input  logic          in_skip,
    input  logic [AW:0]   rd_gray_s,
    output logic [AW:0]   wr_gray,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW:0]   mem_wdata,
    output logic          skip_evt,
    output logic          ovf_err
);
    localparam int DEPTH = 1 << AW;
    localparam int GAP_W = $clog2(MIN_GAP + 2);
    localparam logic [AW:0]      LV_FULL    = (AW+1)'(DEPTH);
    localparam logic [AW:0]      LV_HALF    = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0]      LV_HI      = (AW+1)'(HI_TH);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(MIN_GAP);

    typedef struct packed {
        logic [AW:0]      ptr;
        logic [AW:0]      gray;
        wr_mode_e         mode;
        logic [GAP_W-1:0] gap;
        logic             skip;
        logic             ovf;
    } wr_state_t;

    wr_state_t   st_d, st_q;
    logic [AW:0] rd_bin;
    logic [AW:0] level;
    logic        full;
    logic        draining;
    logic        we_d;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rd_bin   = g2b(rd_gray_s);
        level    = st_q.ptr - rd_bin;
        full     = (level == LV_FULL);
        draining = (st_q.mode == WR_DRAIN) && (level > LV_HALF);
        st_d      = st_q;
        st_d.skip = 1'b0;
        st_d.mode = draining ? WR_DRAIN : WR_PASS;
        we_d      = 1'b0;
        if (st_q.gap != '0) st_d.gap = st_q.gap - 1'b1;
        if (in_en) begin
            if (full) begin
                st_d.ovf  = 1'b1;
                st_d.mode = WR_DRAIN;
            end else if (draining) begin
                st_d.mode = WR_DRAIN;
            end else if (in_skip && (level >= LV_HI) && (st_q.gap == '0)) begin
                st_d.skip = 1'b1;
                st_d.gap  = GAP_RELOAD;
            end else begin
                we_d     = 1'b1;
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = we_d;
    assign mem_waddr = st_q.ptr[AW-1:0];
    assign mem_wdata = {in_skip, in_data};
    assign wr_gray   = st_q.gray;
    assign skip_evt  = st_q.skip;
    assign ovf_err   = st_q.ovf;

    // R4
    skip_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.skip |-> $past(in_en && in_skip));

    // R6
    skip_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.skip |=> !st_q.skip);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
endmodule

// File: rtl/elbuf_rd.sv
module elbuf_rd
    import elbuf_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int LO_TH   = 4,
    parameter int MIN_GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wr_gray_s,
    input  logic [DW:0]   mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rd_gray,
    output logic [DW-1:0] out_data,
    output logic          out_skip,
    output logic          out_valid,
    output logic          ins_evt,
    output logic          udf_err
);
    localparam int DEPTH = 1 << AW;
    localparam int GAP_W = $clog2(MIN_GAP + 2);
    localparam logic [AW:0]      LV_HALF    = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0]      LV_LO      = (AW+1)'(LO_TH);
    localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(MIN_GAP);

    typedef struct packed {
        logic [AW:0]      ptr;
        logic [AW:0]      gray;
        rd_mode_e         mode;
        logic [GAP_W-1:0] gap;
        logic             rep;
        logic [DW-1:0]    data;
        logic             skip;
        logic             valid;
        logic             ins;
        logic             udf;
    } rd_state_t;

    rd_state_t   st_d, st_q;
    logic [AW:0] wr_bin;
    logic [AW:0] level;
    logic        head_skip;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wr_bin    = g2b(wr_gray_s);
        level     = wr_bin - st_q.ptr;
        head_skip = mem_rdata[DW];
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ins   = 1'b0;
        if (st_q.gap != '0) st_d.gap = st_q.gap - 1'b1;
        case (st_q.mode)
            RD_FILL: begin
                if (level >= LV_HALF) st_d.mode = RD_RUN;
            end
            RD_RUN: begin
                if (rd_en) begin
                    if (level == '0) begin
                        st_d.udf  = 1'b1;
                        st_d.mode = RD_FILL;
                    end else begin
                        st_d.data  = mem_rdata[DW-1:0];
                        st_d.skip  = head_skip;
                        st_d.valid = 1'b1;
                        if (head_skip && (level <= LV_LO) && (st_q.gap == '0) && !st_q.rep) begin
                            st_d.ins = 1'b1;
                            st_d.rep = 1'b1;
                            st_d.gap = GAP_RELOAD;
                        end else begin
                            st_d.ptr = st_q.ptr + 1'b1;
                            st_d.rep = 1'b0;
                        end
                    end
                end
            end
            default: st_d.mode = RD_FILL;
        endcase
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.ptr[AW-1:0];
    assign rd_gray   = st_q.gray;
    assign out_data  = st_q.data;
    assign out_skip  = st_q.skip;
    assign out_valid = st_q.valid;
    assign ins_evt   = st_q.ins;
    assign udf_err   = st_q.udf;

    // R5
    ins_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ins && rd_en) |=> (st_q.valid && st_q.skip && $stable(st_q.data) && !st_q.ins));

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.udf |=> st_q.udf);

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !st_q.valid);
endmodule

// File: rtl/elastic_buf.sv
module elastic_buf #(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter int HI_TH   = 12,
    parameter int LO_TH   = 4,
    parameter int MIN_GAP = 3
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_skip,
    output logic          skip_evt,
    output logic          ovf_err,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_skip,
    output logic          rd_valid,
    output logic          ins_evt,
    output logic          udf_err
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wr_gray, wr_gray_s;
    logic [PW-1:0] rd_gray, rd_gray_s;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW:0]   mem_wdata, mem_rdata;

    elbuf_mem #(.W(DW + 1), .AW(AW)) u_mem (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    elbuf_sync #(.W(PW)) u_sync_rd2wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    elbuf_sync #(.W(PW)) u_sync_wr2rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    elbuf_wr #(.DW(DW), .AW(AW), .HI_TH(HI_TH), .MIN_GAP(MIN_GAP)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .in_en     (wr_en),
        .in_data   (wr_data),
        .in_skip   (wr_skip),
        .rd_gray_s (rd_gray_s),
        .wr_gray   (wr_gray),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .skip_evt  (skip_evt),
        .ovf_err   (ovf_err)
    );

    elbuf_rd #(.DW(DW), .AW(AW), .LO_TH(LO_TH), .MIN_GAP(MIN_GAP)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .rd_en     (rd_en),
        .wr_gray_s (wr_gray_s),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .rd_gray   (rd_gray),
        .out_data  (rd_data),
        .out_skip  (rd_skip),
        .out_valid (rd_valid),
        .ins_evt   (ins_evt),
        .udf_err   (udf_err)
    );
endmodule

// File: tb/test_elastic_buf.sv
module test_elastic_buf;
    localparam int DW      = 8;
    localparam int MIN_GAP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          w_en = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic          w_skip = 1'b0;
    logic          rd_en = 1'b0;
    logic          skip_evt, ovf_err, rd_skip, rd_valid, ins_evt, udf_err;
    logic [DW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    elastic_buf i_elastic_buf (
        .wr_clk   (clk),
        .wr_rst_n (rst_n),
        .wr_en    (w_en),
        .wr_data  (w_data),
        .wr_skip  (w_skip),
        .skip_evt (skip_evt),
        .ovf_err  (ovf_err),
        .rd_clk   (clk),
        .rd_rst_n (rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_skip  (rd_skip),
        .rd_valid (rd_valid),
        .ins_evt  (ins_evt),
        .udf_err  (udf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs as seen at the last rising edge
    logic          p_en = 1'b0, p_skip = 1'b0, p_rd = 1'b0;
    logic [DW-1:0] p_data = '0;
    always @(posedge clk) begin
        p_en   <= w_en;
        p_skip <= w_skip;
        p_data <= w_data;
        p_rd   <= rd_en;
    end

    logic [DW:0] expq[$];
    bit cmp_on   = 1'b1;
    bit dup_pend = 1'b0;
    int cyc = 0, last_skip = -100, last_ins = -100;
    int n_skip = 0, n_ins = 0, n_valid = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (skip_evt) begin
                chk(p_en && p_skip, "R4 deleted word flag", int'(p_skip), 1);
                chk(cyc - last_skip >= MIN_GAP + 1, "R6 skip spacing", cyc - last_skip, MIN_GAP + 1);
                last_skip = cyc;
                n_skip++;
            end else if (p_en && cmp_on) begin
                expq.push_back({p_skip, p_data});
            end
            if (ins_evt) begin
                chk(rd_valid && rd_skip, "R5 repeated word flag", int'(rd_skip), 1);
                chk(cyc - last_ins >= MIN_GAP + 1, "R6 insert spacing", cyc - last_ins, MIN_GAP + 1);
                last_ins = cyc;
                n_ins++;
            end
            if (rd_valid) begin
                n_valid++;
                chk(p_rd, "R10 valid without request", int'(p_rd), 1);
                if (cmp_on) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R1 unexpected word", int'({rd_skip, rd_data}), -1);
                    end else if (dup_pend) begin
                        chk({rd_skip, rd_data} == expq[0], "R5 duplicate word",
                            int'({rd_skip, rd_data}), int'(expq[0]));
                        void'(expq.pop_front());
                        dup_pend = 1'b0;
                    end else begin
                        chk({rd_skip, rd_data} == expq[0], "R1 word order",
                            int'({rd_skip, rd_data}), int'(expq[0]));
                        if (ins_evt) dup_pend = 1'b1;
                        else void'(expq.pop_front());
                    end
                end
            end
        end
    end

    int seq = 0;
    // wr active wk of every wm cycles, rd active rk of every rm, every sm-th word flagged
    task automatic run(input int n, input int wm, input int wk, input int rm, input int rk, input int sm);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            w_en  = (i % wm) < wk;
            rd_en = (i % rm) < rk;
            if (w_en) begin
                w_data = DW'(seq);
                w_skip = (sm > 0) && ((seq % sm) == sm - 1);
                seq++;
            end else begin
                w_skip = 1'b0;
            end
        end
        @(negedge clk);
        w_en = 1'b0;
        w_skip = 1'b0;
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            w_en  = 1'b0;
            rd_en = r;
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v0, s0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9
        chk({rd_valid, skip_evt, ins_evt, ovf_err, udf_err, rd_skip} == '0, "R9 reset outputs",
            int'({rd_valid, skip_evt, ins_evt, ovf_err, udf_err, rd_skip}), 0);
        chk(rd_data == '0, "R9 reset data", int'(rd_data), 0);

        // R2: below half full, no output
        run(7, 1, 1, 1, 1, 0);
        idle(20, 1'b1);
        chk(n_valid == 0, "R2 no read before half", n_valid, 0);

        // balanced rates
        run(200, 1, 1, 1, 1, 8);
        idle(2, 1'b1);

        // slow reader: deletions expected (R3)
        s0 = n_skip;
        run(400, 1, 1, 5, 4, 4);
        chk(n_skip > s0, "R3 deletions under slow reader", n_skip - s0, 1);
        chk(!ovf_err, "R7 no overflow while matching", int'(ovf_err), 0);

        // slow writer: insertions expected (R5)
        i0 = n_ins;
        run(400, 5, 4, 1, 1, 3);
        chk(n_ins > i0, "R5 insertions under slow writer", n_ins - i0, 1);
        chk(!udf_err, "R8 no underflow while matching", int'(udf_err), 0);
        chk(!ovf_err, "R7 no overflow after sweeps", int'(ovf_err), 0);

        // overflow: reader stopped, unflagged words only
        cmp_on = 1'b0;
        s0 = n_skip;
        run(30, 1, 1, 1, 0, 0);
        idle(3, 1'b0);
        chk(ovf_err, "R7 overflow flag", int'(ovf_err), 1);
        chk(n_skip == s0, "R4 no deletion of unflagged words", n_skip - s0, 0);

        // underflow: writer stopped
        idle(40, 1'b1);
        chk(udf_err, "R8 underflow flag", int'(udf_err), 1);
        chk(!rd_valid, "R8 no word when empty", int'(rd_valid), 0);
        chk(ovf_err, "R7 overflow flag sticky", int'(ovf_err), 1);

        // recovery: pause until half, then resume in order
        expq.delete();
        dup_pend = 1'b0;
        cmp_on = 1'b1;
        v0 = n_valid;
        run(5, 1, 1, 1, 1, 0);
        idle(20, 1'b1);
        chk(n_valid == v0, "R8 paused below half", n_valid - v0, 0);
        run(20, 1, 1, 1, 1, 0);
        idle(40, 1'b1);
        chk(n_valid - v0 == 25, "R8 reading resumed", n_valid - v0, 25);
        chk(expq.size() == 0, "R1 all words delivered", expq.size(), 0);
        chk(udf_err, "R8 underflow flag sticky", int'(udf_err), 1);

        // R10: reader held off, nothing delivered
        v0 = n_valid;
        run(10, 1, 1, 1, 0, 0);
        idle(10, 1'b0);
        chk(n_valid == v0, "R10 no delivery with rd_en low", n_valid - v0, 0);
        idle(30, 1'b1);
        chk(expq.size() == 0 && n_valid - v0 == 10, "R1 held words delivered", n_valid - v0, 10);

        summary();
    end
endmodule